// File: doc/BRIEF.md
# Four-Word Random Output Buffer

This block sits between a conditioning stage that produces 128-bit results and a 32-bit data read port. It holds a staging register for one pending result and a four-word output buffer. When the buffer is empty, or is emptied by the read in the current cycle, a staged result is copied into the buffer on that clock edge. In the same cycle a round-start request goes to the conditioner so that it begins computing the next result. Words leave the buffer least significant first.

A data-ready flag is high whenever at least one word can be read. A one-cycle event pulse marks each rising edge of that flag and serves as the interrupt source. Reading while the flag is low returns zero and changes nothing. A seed-error input stops all further refills and round starts until a soft reset. Words already in the buffer can still be read. A soft reset empties both storage stages, clears the stop, and restarts the conditioner with a fresh round request. The conditioner sits outside this block; the bench models it as a producer with a fixed latency.

Top module: `rng_out_buf`

## Requirements
- R1: After the asynchronous reset, data-ready, read data and the rise event are 0. The round-start request is 1 in the first cycle after reset.
- R2: The words of a 128-bit result are read in this order: bits [31:0] first, then [63:32], then [95:64], then [127:96].
- R3: While data-ready is 1, read data shows the oldest unread word without waiting for a clock edge. A read strobe removes that word at the next edge.
- R4: Data-ready is 1 exactly when the buffer holds at least one word. Without a read it never falls.
- R5: While data-ready is 0, read data is 0x0000_0000, and a read strobe has no effect on the buffer.
- R6: A staged result moves into the buffer on the edge after which the buffer would otherwise be empty. Round-start is asserted in that same cycle.
- R7: When the fourth word is read while a result is staged, data-ready stays 1 without a gap.
- R8: The rise event is a single-cycle pulse, high exactly in the first cycle in which data-ready is 1 after being 0.
- R9: An incoming result is accepted only when the staging register is empty or is being emptied in that cycle. Any other incoming result is ignored.
- R10: From the cycle in which seed error is asserted until the next soft reset, there are no refills, no round-starts and no accepted results. Words already buffered stay readable.
- R11: A soft reset empties the buffer and the staging register and clears the seed stop. Data-ready is 0 in the next cycle, and round-start is asserted in the cycle after the soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_data_i | input | 128 | Conditioned result |
| res_valid_i | input | 1 | Result strobe |
| rd_i | input | 1 | Data-port read strobe |
| soft_rst_i | input | 1 | Synchronous soft reset |
| seed_err_i | input | 1 | Seed error, stops refills |
| rd_data_o | output | 32 | Oldest word, or 0 when empty |
| drdy_o | output | 1 | Data-ready flag |
| round_start_o | output | 1 | Request to start a conditioning round |
| drdy_rise_o | output | 1 | Pulse on a rising edge of data-ready |

## Verification
The bench goes after the refill that coincides with the fourth read. A design that waits one cycle there shows a one-cycle drop of data-ready and a spurious rise event; a design that loads before the read shifts or repeats a word. It injects a second result while one is already staged: a design that overwrites the staging register returns the wrong block of words. It also reads an empty buffer, where a wrong design would return stale data or wrap its pointer. Finally it checks that a seed error silences round-start while the remaining words drain, and that a soft reset empties both stages and issues a new round request.

// File: rtl/rng_out_buf_pkg.sv
package rng_out_buf_pkg;
  parameter int unsigned ROB_WORD_W = 32;
  parameter int unsigned ROB_DEPTH  = 4;
endpackage

// File: rtl/rob_stage.sv
module rob_stage #(
  parameter int unsigned RES_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             stop_i,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_data_i,
  input  logic             take_i,
  output logic [RES_W-1:0] data_o,
  output logic             vld_o
);
  logic [RES_W-1:0] data_q;
  logic             vld_q;
  logic             accept;

  // a slot frees up in the same cycle the buffer takes the staged result
  assign accept = res_valid_i && !stop_i && !soft_rst_i && (!vld_q || take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else if (soft_rst_i) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else if (accept) begin
      data_q <= res_data_i;
      vld_q  <= 1'b1;
    end else if (take_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/rob_words.sv
module rob_words #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned RES_W = WORD_W * DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              rd_i,
  input  logic              load_i,
  input  logic [RES_W-1:0]  load_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [WORD_W-1:0] words_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  head_q;
  logic              rd_ok;

  assign rd_ok = rd_i && (cnt_q != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    words_q[i] <= '0;
      else if (load_i && !soft_rst_i) words_q[i] <= load_data_i[i*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      head_q <= '0;
    end else if (soft_rst_i) begin
      cnt_q  <= '0;
      head_q <= '0;
    end else if (load_i) begin
      cnt_q  <= CNT_W'(DEPTH);
      head_q <= '0;
    end else if (rd_ok) begin
      cnt_q  <= cnt_q - 1'b1;
      head_q <= head_q + 1'b1;
    end
  end

  assign rd_data_o = (cnt_q != '0) ? words_q[head_q] : '0;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             seed_err_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             stg_vld_i,
  output logic             move_o,
  output logic             stop_o,
  output logic             round_start_o,
  output logic             drdy_o,
  output logic             drdy_rise_o
);
  logic stop_q, kick_q, drdy_q;
  logic stop_w, drains;

  assign stop_w = stop_q || seed_err_i;
  // buffer is empty after this edge
  assign drains = (cnt_i == '0) || ((cnt_i == CNT_W'(1)) && rd_i);
  assign move_o = stg_vld_i && drains && !stop_w && !soft_rst_i;
  assign round_start_o = !soft_rst_i && !stop_w && (kick_q || move_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      kick_q <= 1'b1;
      drdy_q <= 1'b0;
    end else begin
      stop_q <= soft_rst_i ? 1'b0 : stop_w;
      kick_q <= soft_rst_i;
      drdy_q <= drdy_o;
    end
  end

  assign drdy_o      = (cnt_i != '0);
  assign drdy_rise_o = drdy_o && !drdy_q;
  assign stop_o      = stop_w;
endmodule

// File: rtl/rng_out_buf.sv
module rng_out_buf
  import rng_out_buf_pkg::*;
#(
  parameter int unsigned WORD_W = ROB_WORD_W,
  parameter int unsigned DEPTH  = ROB_DEPTH,
  localparam int unsigned RES_W = WORD_W * DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RES_W-1:0]  res_data_i,
  input  logic              res_valid_i,
  input  logic              rd_i,
  input  logic              soft_rst_i,
  input  logic              seed_err_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              drdy_o,
  output logic              round_start_o,
  output logic              drdy_rise_o
);
  logic [RES_W-1:0] stg_data;
  logic             stg_vld, move, stop;
  logic [CNT_W-1:0] cnt;

  rob_stage #(.RES_W(RES_W)) u_stage (
    .clk_i, .rst_ni, .soft_rst_i,
    .stop_i(stop), .res_valid_i, .res_data_i,
    .take_i(move), .data_o(stg_data), .vld_o(stg_vld)
  );

  rob_words #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_words (
    .clk_i, .rst_ni, .soft_rst_i, .rd_i,
    .load_i(move), .load_data_i(stg_data),
    .rd_data_o, .cnt_o(cnt)
  );

  rob_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .soft_rst_i, .seed_err_i, .rd_i,
    .cnt_i(cnt), .stg_vld_i(stg_vld),
    .move_o(move), .stop_o(stop),
    .round_start_o, .drdy_o, .drdy_rise_o
  );
endmodule

// File: rtl/rng_out_buf_chk.sv
module rng_out_buf_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              soft_rst_i,
  input logic              seed_err_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              drdy_o,
  input logic              round_start_o,
  input logic              drdy_rise_o
);
  a_r5_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_o |-> rd_data_o == '0);

  a_r8_rise_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_rise_o |-> (drdy_o && !$past(drdy_o)));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drdy_o && !rd_i && !soft_rst_i) |=> drdy_o);

  a_r11_soft_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !drdy_o);

  a_r10_seed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_err_i && !soft_rst_i) |=> (!round_start_o || soft_rst_i));
endmodule

bind rng_out_buf rng_out_buf_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .soft_rst_i(soft_rst_i),
  .seed_err_i(seed_err_i), .rd_data_o(rd_data_o), .drdy_o(drdy_o),
  .round_start_o(round_start_o), .drdy_rise_o(drdy_rise_o)
);

// File: tb/rng_out_buf_tb.sv
module rng_out_buf_tb;
  localparam int LAT = 6;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] res_data_i = '0;
  logic         res_valid_i = 1'b0;
  logic         rd_i = 1'b0, soft_rst_i = 1'b0, seed_err_i = 1'b0;
  logic [31:0]  rd_data_o;
  logic         drdy_o, round_start_o, drdy_rise_o;

  rng_out_buf u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [31:0]  mq[$];
  logic [127:0] mstg = '0;
  bit mstg_v = 0, mstop = 0, mkick = 1, mprev = 0;
  bit rs_exp = 0;

  // producer
  int  prod_cnt = 0;
  bit  inj = 0, grab_first = 1;
  logic [127:0] first_res = '0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    res_valid_i = (prod_cnt == 1) || inj;
    res_data_i  = {$urandom, $urandom, $urandom, $urandom};
    if (res_valid_i && grab_first && rst_ni) begin
      first_res  = res_data_i;
      grab_first = 0;
    end
    #2;
    if (rst_ni) begin
      bit rd_eff, stop_w, move, drdy_e;
      logic [31:0] dat_e;
      rd_eff = rd_i && mq.size() > 0;
      stop_w = mstop || seed_err_i;
      move   = mstg_v && !stop_w && !soft_rst_i && (mq.size() - int'(rd_eff) == 0);
      rs_exp = !soft_rst_i && !stop_w && (mkick || move);
      drdy_e = mq.size() > 0;
      dat_e  = drdy_e ? mq[0] : 32'h0;
      chk(drdy_o == drdy_e, "R4 drdy", drdy_o, drdy_e);
      chk(rd_data_o == dat_e, "R3 rd_data", rd_data_o, dat_e);
      chk(round_start_o == rs_exp, "R6 round_start", round_start_o, rs_exp);
      chk(drdy_rise_o == (drdy_e && !mprev), "R8 rise", drdy_rise_o, drdy_e && !mprev);
    end
  end

  always @(posedge clk_i) begin
    if (rst_ni) begin
      bit rd_eff, stop_w, move, acc;
      rd_eff = rd_i && mq.size() > 0;
      stop_w = mstop || seed_err_i;
      move   = mstg_v && !stop_w && !soft_rst_i && (mq.size() - int'(rd_eff) == 0);
      acc    = res_valid_i && !stop_w && !soft_rst_i && (!mstg_v || move);
      mprev  = mq.size() > 0;
      if (soft_rst_i) begin
        mq.delete();
        mstg_v = 0; mstop = 0; mkick = 1;
      end else begin
        if (rd_eff) void'(mq.pop_front());
        if (move) for (int i = 0; i < 4; i++) mq.push_back(mstg[i*32 +: 32]);
        if (acc) begin mstg = res_data_i; mstg_v = 1; end
        else if (move) mstg_v = 0;
        mstop = stop_w; mkick = 0;
      end
      if (soft_rst_i) prod_cnt = 0;
      else begin
        if (res_valid_i && prod_cnt == 1) prod_cnt = 0;
        else if (prod_cnt > 1) prod_cnt--;
        if (rs_exp) prod_cnt = LAT;
      end
    end
  end

  task automatic wait_drdy();
    for (int i = 0; i < 200 && !drdy_o; i++) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] saved;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(drdy_o == 0 && rd_data_o == 0 && drdy_rise_o == 0, "R1 reset outputs", {drdy_o, rd_data_o}, 0);
    chk(round_start_o == 1, "R1 first round_start", round_start_o, 1);
    @(negedge clk_i);
    wait_drdy();
    #1;
    chk(drdy_rise_o == 1, "R8 first rise", drdy_rise_o, 1);
    // read immediately: staging still empty, buffer drains
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i); rd_i = 1; #1;
      chk(rd_data_o == first_res[k*32 +: 32], "R2 word order", rd_data_o, first_res[k*32 +: 32]);
    end
    @(negedge clk_i); #1;
    if (drdy_o == 0) begin
      chk(rd_data_o == 0, "R5 empty read zero", rd_data_o, 0);
    end
    @(negedge clk_i); rd_i = 0;
    wait_drdy();
    repeat (20) @(negedge clk_i);
    // staged result present: fourth read refills without a gap
    for (int k = 0; k < 4; k++) begin
      rd_i = 1; @(negedge clk_i);
    end
    rd_i = 0; #1;
    chk(drdy_o == 1, "R7 drdy across refill", drdy_o, 1);
    repeat (20) @(negedge clk_i);
    // inject a second result while staging is full
    saved = mstg;
    inj = 1; @(negedge clk_i); inj = 0;
    for (int k = 0; k < 4; k++) begin
      rd_i = 1; @(negedge clk_i);
    end
    rd_i = 0; #1;
    chk(rd_data_o == saved[31:0], "R9 extra result ignored", rd_data_o, saved[31:0]);
    // random traffic
    for (int c = 0; c < 600; c++) begin
      @(negedge clk_i); rd_i = ($urandom % 3) == 0;
    end
    rd_i = 0;
    wait_drdy();
    @(negedge clk_i);
    seed_err_i = 1; @(negedge clk_i); seed_err_i = 0;
    for (int c = 0; c < 40; c++) begin
      rd_i = 1; #1;
      chk(round_start_o == 0, "R10 no round after seed error", round_start_o, 0);
      @(negedge clk_i);
    end
    rd_i = 0; #1;
    chk(drdy_o == 0, "R10 no refill after seed error", drdy_o, 0);
    repeat (30) @(negedge clk_i);
    #1;
    chk(drdy_o == 0, "R10 stays empty", drdy_o, 0);
    @(negedge clk_i);
    soft_rst_i = 1; @(negedge clk_i); soft_rst_i = 0; #1;
    chk(drdy_o == 0, "R11 empty after soft reset", drdy_o, 0);
    chk(round_start_o == 1, "R11 round after soft reset", round_start_o, 1);
    wait_drdy();
    for (int c = 0; c < 200; c++) begin
      @(negedge clk_i); rd_i = ($urandom % 2) == 0;
    end
    rd_i = 0;
    // soft reset with a full buffer
    wait_drdy();
    @(negedge clk_i); soft_rst_i = 1; @(negedge clk_i); soft_rst_i = 0; #1;
    chk(drdy_o == 0 && rd_data_o == 0, "R11 full buffer cleared", {drdy_o, rd_data_o}, 0);
    repeat (30) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule